// File: doc/BRIEF.md
# Triggered Timebase Divider Timer

A synchronous long-period timer. A slow timebase signal is sampled by the system clock, and its falling edges advance a binary divider chain. A rising edge on the trigger input clears the chain and starts a count. While the count runs, the block drives a half-rate output from the lowest stage of the chain and a long-period output from the highest stage.

A mode input selects one of two behaviours. In one-shot mode the long output gives a single low pulse that lasts half the chain period, 128 timebase periods at the default width. The block then returns to idle. In free-run mode the chain keeps dividing, and the long output alternates between equal low and high halves.

The timebase, trigger and functional reset inputs each pass through a two-flop synchroniser. All outputs are actively driven high and low, and a busy output reports whether a count is in progress.

Top module: `tbdiv_timer`

## Requirements
- R1: After system reset the block is idle: div2_o = 1, divn_o = 1, busy_o = 0.
- R2: A rising edge on trig_i clears the chain and drives div2_o = 0, divn_o = 0, busy_o = 1. The outputs change 3 clock cycles after the input changes.
- R3: A rising edge on tb_i has no effect on the outputs. Only falling edges are counted.
- R4: While counting, div2_o equals the least significant bit of the number of falling timebase edges counted since the trigger, so it toggles on every counted edge.
- R5: divn_o stays low for the first 127 counted falling edges after a trigger and goes high on the 128th.
- R6: With oneshot_i = 1, the 128th counted edge returns the block to idle (div2_o = 1, divn_o = 1, busy_o = 0). Further timebase edges leave it idle.
- R7: With oneshot_i = 0, divn_o equals bit 7 of the edge count modulo 256, so it is high after 128 edges and low again after 256. busy_o stays high.
- R8: reset_i high while trig_i is low puts the block into idle.
- R9: reset_i high while trig_i is held high has no effect on the outputs.
- R10: A trigger rising edge and a timebase falling edge detected in the same cycle resolve to the trigger, and the count restarts at zero.
- R11: While idle, timebase edges are ignored and the outputs stay at their idle values.
- R12: A trigger rising edge during a count restarts the count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset, asynchronous |
| reset_i | input | 1 | Functional reset to idle, active high, honoured only while the trigger is low |
| trig_i | input | 1 | Trigger; a rising edge starts or restarts a count |
| tb_i | input | 1 | Timebase; falling edges advance the chain |
| oneshot_i | input | 1 | 1 = one-shot, 0 = free-run |
| div2_o | output | 1 | Lowest chain stage, high while idle |
| divn_o | output | 1 | Highest chain stage, high while idle |
| busy_o | output | 1 | High while a count is in progress |

## Verification
Every input passes through two synchroniser flops before it is used. The edge or level detected at that point then updates the state register. Each output change is therefore due on the third rising clock edge after the input changes, and this holds for the trigger, the timebase and the functional reset alike.

The driver changes inputs on falling clock edges. For each stimulus it queues the expected output triple, stamped with the cycle three rising edges later. The monitor compares that entry at the falling edge of that cycle.

Timebase levels are held for two cycles, so every edge is seen as its own event.

// File: rtl/tbdiv_pkg.sv
package tbdiv_pkg;

  typedef enum logic {
    TBD_IDLE = 1'b0,
    TBD_RUN  = 1'b1
  } tbd_state_e;

  typedef struct packed {
    logic half;
    logic longp;
    logic busy;
  } tbd_outs_t;

endpackage

// File: rtl/tbdiv_sync.sv
module tbdiv_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level
);

  logic [STAGES-1:0] sr;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sr[0] <= 1'b0;
          else        sr[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sr[gi] <= 1'b0;
          else        sr[gi] <= sr[gi-1];
        end
      end
    end
  endgenerate

  assign level = sr[STAGES-1];

endmodule

// File: rtl/tbdiv_edge.sv
module tbdiv_edge #(
  parameter bit FALLING = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic pulse
);

  logic prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= level;
  end

  generate
    if (FALLING) begin : g_fall
      assign pulse = prev & ~level;
    end else begin : g_rise
      assign pulse = level & ~prev;
    end
  endgenerate

endmodule

// File: rtl/tbdiv_core.sv
module tbdiv_core
  import tbdiv_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_rise,
  input  logic             tb_fall,
  input  logic             rst_req,
  input  logic             oneshot,
  output logic [CNT_W-1:0] count,
  output tbd_state_e       state,
  output logic             pulse_done
);

  localparam logic [CNT_W-1:0] HALF_LAST = {1'b0, {(CNT_W-1){1'b1}}};

  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] c);
    return c + {{(CNT_W-1){1'b0}}, 1'b1};
  endfunction

  logic advance;

  assign advance    = (state == TBD_RUN) && tb_fall && !trig_rise && !rst_req;
  assign pulse_done = advance && oneshot && (count == HALF_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= TBD_IDLE;
      count <= '0;
    end else if (trig_rise) begin
      state <= TBD_RUN;
      count <= '0;
    end else if (rst_req || pulse_done) begin
      state <= TBD_IDLE;
      count <= '0;
    end else if (advance) begin
      count <= step(count);
    end
  end

endmodule

// File: rtl/tbdiv_timer.sv
module tbdiv_timer
  import tbdiv_pkg::*;
#(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned SYNC_STGS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic reset_i,
  input  logic trig_i,
  input  logic tb_i,
  input  logic oneshot_i,
  output logic div2_o,
  output logic divn_o,
  output logic busy_o
);

  logic             tb_lvl, trig_lvl, rst_lvl;
  logic             tb_fall, trig_rise, rst_req;
  logic [CNT_W-1:0] count;
  tbd_state_e       state;
  logic             pulse_done;
  tbd_outs_t        outs;

  function automatic tbd_outs_t drive_outs(input tbd_state_e st,
                                           input logic [CNT_W-1:0] c);
    tbd_outs_t o;
    if (st == TBD_RUN) begin
      o.half  = c[0];
      o.longp = c[CNT_W-1];
      o.busy  = 1'b1;
    end else begin
      o.half  = 1'b1;
      o.longp = 1'b1;
      o.busy  = 1'b0;
    end
    return o;
  endfunction

  tbdiv_sync #(.STAGES(SYNC_STGS)) u_sync_tb (
    .clk(clk), .rst_n(rst_n), .din(tb_i), .level(tb_lvl));
  tbdiv_sync #(.STAGES(SYNC_STGS)) u_sync_trig (
    .clk(clk), .rst_n(rst_n), .din(trig_i), .level(trig_lvl));
  tbdiv_sync #(.STAGES(SYNC_STGS)) u_sync_rst (
    .clk(clk), .rst_n(rst_n), .din(reset_i), .level(rst_lvl));

  tbdiv_edge #(.FALLING(1'b1)) u_edge_tb (
    .clk(clk), .rst_n(rst_n), .level(tb_lvl), .pulse(tb_fall));
  tbdiv_edge #(.FALLING(1'b0)) u_edge_trig (
    .clk(clk), .rst_n(rst_n), .level(trig_lvl), .pulse(trig_rise));

  assign rst_req = rst_lvl && !trig_lvl;

  tbdiv_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .trig_rise(trig_rise), .tb_fall(tb_fall),
    .rst_req(rst_req), .oneshot(oneshot_i), .count(count), .state(state),
    .pulse_done(pulse_done));

  assign outs   = drive_outs(state, count);
  assign div2_o = outs.half;
  assign divn_o = outs.longp;
  assign busy_o = outs.busy;

endmodule

// File: rtl/tbdiv_chk.sv
module tbdiv_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             trig_rise,
  input logic             tb_fall,
  input logic             rst_req,
  input logic             oneshot_i,
  input logic [CNT_W-1:0] count,
  input logic             pulse_done,
  input logic             div2_o,
  input logic             divn_o,
  input logic             busy_o
);

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (div2_o && divn_o)); // R1

  AST_TRIG_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    trig_rise |=> (busy_o && !div2_o && !divn_o)); // R2

  AST_HOLD_NO_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!tb_fall && !trig_rise && !rst_req) |=> ($stable(count) && $stable(busy_o))); // R3

  AST_DIV2_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && tb_fall && !pulse_done && !trig_rise && !rst_req) |=> (div2_o != $past(div2_o))); // R4

  AST_ONESHOT_END: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_done |=> !busy_o); // R6

  AST_FREE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !oneshot_i && !rst_req) |=> busy_o); // R7

  AST_RST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !busy_o); // R8

  AST_IDLE_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !trig_rise) |=> !busy_o); // R11

endmodule

bind tbdiv_timer tbdiv_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .trig_rise(trig_rise), .tb_fall(tb_fall),
  .rst_req(rst_req), .oneshot_i(oneshot_i), .count(count),
  .pulse_done(pulse_done), .div2_o(div2_o), .divn_o(divn_o), .busy_o(busy_o));

// File: tb/tb_tbdiv_timer.sv
module tb_tbdiv_timer;

  logic clk = 1'b0;
  logic rst_n, reset_i, trig_i, tb_i, oneshot_i;
  logic div2_o, divn_o, busy_o;

  always #10 clk = ~clk;

  tbdiv_timer dut (
    .clk(clk), .rst_n(rst_n), .reset_i(reset_i), .trig_i(trig_i),
    .tb_i(tb_i), .oneshot_i(oneshot_i),
    .div2_o(div2_o), .divn_o(divn_o), .busy_o(busy_o));

  int  cyc = 0;
  int  total = 0;
  int  fails = 0;
  bit  done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int    due;
    logic  d2;
    logic  dn;
    logic  bsy;
    string tag;
  } exp_t;

  exp_t q[$];
  exp_t cur;

  // reference model
  logic       m_run = 1'b0;
  logic [7:0] m_cnt = 8'd0;
  logic       m_one = 1'b1;

  task automatic chk(input string tag, input logic a2, input logic an,
                     input logic ab, input logic e2, input logic en,
                     input logic eb);
    total++;
    if (a2 !== e2 || an !== en || ab !== eb) begin
      fails++;
      $display("FAIL %s: got div2=%b divn=%b busy=%b, expected div2=%b divn=%b busy=%b",
               tag, a2, an, ab, e2, en, eb);
    end
  endtask

  task automatic expect_due(input string tag);
    exp_t e;
    e.due = cyc + 3;
    e.d2  = m_run ? m_cnt[0] : 1'b1;
    e.dn  = m_run ? m_cnt[7] : 1'b1;
    e.bsy = m_run;
    e.tag = tag;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      cur = q.pop_front();
      chk(cur.tag, div2_o, divn_o, busy_o, cur.d2, cur.dn, cur.bsy);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic m_fall();
    if (m_run) begin
      m_cnt = m_cnt + 8'd1;
      if (m_one && m_cnt == 8'd128) begin
        m_run = 1'b0;
        m_cnt = 8'd0;
      end
    end
  endtask

  task automatic tb_pulse(input string tag);
    tb_i = 1'b1;
    expect_due("R3");
    tick(2);
    tb_i = 1'b0;
    m_fall();
    expect_due(tag);
    tick(2);
  endtask

  task automatic trig_pulse(input string tag);
    trig_i = 1'b1;
    m_run  = 1'b1;
    m_cnt  = 8'd0;
    expect_due(tag);
    tick(3);
    trig_i = 1'b0;
    tick(3);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; reset_i = 1'b0; trig_i = 1'b0; tb_i = 1'b0; oneshot_i = 1'b1;
    tick(5);
    rst_n = 1'b1;
    tick(1);
    chk("R1", div2_o, divn_o, busy_o, 1'b1, 1'b1, 1'b0);
    tick(2);
    chk("R1", div2_o, divn_o, busy_o, 1'b1, 1'b1, 1'b0);

    // R11: idle ignores timebase
    for (int i = 0; i < 3; i++) tb_pulse("R11");

    // R2 trigger, R4 half-rate output, R12 retrigger
    trig_pulse("R2");
    for (int i = 0; i < 5; i++) tb_pulse("R4");
    trig_pulse("R12");

    // R5 / R6 one-shot pulse
    for (int i = 1; i <= 128; i++) tb_pulse(i == 128 ? "R6" : "R5");
    for (int i = 0; i < 2; i++) tb_pulse("R6");

    // R8 functional reset while trigger low
    trig_pulse("R2");
    for (int i = 0; i < 10; i++) tb_pulse("R4");
    reset_i = 1'b1;
    m_run = 1'b0;
    m_cnt = 8'd0;
    expect_due("R8");
    tick(4);
    reset_i = 1'b0;
    tick(3);

    // R9 reset ignored while trigger held high
    trig_i = 1'b1;
    m_run = 1'b1;
    m_cnt = 8'd0;
    expect_due("R2");
    tick(4);
    for (int i = 0; i < 3; i++) tb_pulse("R9");
    reset_i = 1'b1;
    expect_due("R9");
    tick(5);
    expect_due("R9");
    reset_i = 1'b0;
    tick(4);
    trig_i = 1'b0;
    tick(3);
    tb_pulse("R9");

    // R7 free-run
    reset_i = 1'b1;
    m_run = 1'b0;
    m_cnt = 8'd0;
    expect_due("R8");
    tick(4);
    reset_i = 1'b0;
    tick(3);
    oneshot_i = 1'b0;
    m_one = 1'b0;
    tick(2);
    trig_pulse("R7");
    for (int i = 0; i < 300; i++) tb_pulse("R7");

    // R10 simultaneous trigger edge and timebase fall
    tb_i = 1'b1;
    expect_due("R3");
    tick(2);
    tb_i   = 1'b0;
    trig_i = 1'b1;
    m_run  = 1'b1;
    m_cnt  = 8'd0;
    expect_due("R10");
    tick(3);
    trig_i = 1'b0;
    tick(3);
    tb_pulse("R10");

    tick(8);
    finish_run();
  end

endmodule